// File: doc/BRIEF.md
# Integer ALU with Immediate Operand Selection

This block is the integer execution unit of a simple load-store processor. On each clock it takes an operation code, two 32-bit register operands, a 16-bit immediate field and a 5-bit shift count. It returns a 32-bit result with a zero flag and a signed-overflow flag. The set covers signed and unsigned addition and subtraction, four bitwise operations, signed and unsigned less-than compares, three shifts and an upper-immediate load.

A select input replaces the second register operand with the immediate. The immediate is widened according to the operation. It is sign-extended for arithmetic and compares, and zero-extended for bitwise operations. The next value is computed in combinational logic and captured in one output register, so results appear one clock after the operands are presented. Multiply, divide, trapping on overflow and register write-back belong to other blocks.

Top module: `alu_core`

## Requirements
- R1: The outputs are registered: `result_o`, `zero_o` and `ovf_o` reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, `result_o` is 0, `zero_o` is 1 and `ovf_o` is 0.
- R2: Operation codes on `op_i` are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 SLL, 11 SRL, 12 SRA and 13 LUI. ADD and ADDU return A+B, and SUB and SUBU return A−B, all modulo 2^32.
- R3: `ovf_o` is 1 only for ADD and SUB when the two's-complement result does not fit in 32 bits. ADDU, SUBU and every other code give `ovf_o` = 0.
- R4: When `use_imm_i` is 1, codes 0, 1, 2, 3, 8 and 9 use `imm_i` sign-extended to 32 bits as B; when `use_imm_i` is 0, B is `b_i` and `imm_i` has no effect.
- R5: When `use_imm_i` is 1, codes 4 to 7 use `imm_i` zero-extended to 32 bits as B.
- R6: AND, OR and XOR return the bitwise function of A and B. NOR returns the complement of (A OR B).
- R7: SLT returns 1 when A < B as two's-complement values. SLTU returns 1 when A < B as unsigned values. Otherwise both return 0, and bits 31:1 are always 0.
- R8: SLL and SRL shift A by `shamt_i` (0 to 31) and fill with zeros. SRA shifts right and fills with copies of A bit 31.
- R9: LUI returns `imm_i` in bits 31:16 and zeros in bits 15:0, whatever A, B and `use_imm_i` are.
- R10: `zero_o` is 1 exactly when the registered 32-bit result is 0, for every code.
- R11: Codes 14 and 15 are unused. They return result 0, with `zero_o` = 1 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (R2) |
| use_imm_i | input | 1 | 1: B comes from the extended immediate |
| a_i | input | 32 | Operand A, also the shift source |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift count |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered result-is-zero flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The hardest cases to reach from the ports are those where operand width decides the answer. Signed overflow appears only at the two ends of the 32-bit range. A compare against an all-ones immediate has one answer when the value is signed and another when it is unsigned. The stimulus targets these cases directly. It adds and subtracts across 0x7FFFFFFF and 0x80000000, including zero minus the most negative value. It compares zero against immediate 0xFFFF in both compare forms. It shifts by counts 0 and 31. A seeded random pass, judged by an independent model, then covers the remaining combinations of operation code and operand select.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13
    } alu_op_e;

    // Arithmetic and compare codes widen the immediate with its sign bit.
    function automatic logic op_sign_ext(input alu_op_e op);
        return op inside {OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_SLT, OP_SLTU};
    endfunction

    // Codes that drive the shared adder in subtract mode.
    function automatic logic op_uses_sub(input alu_op_e op);
        return op inside {OP_SUB, OP_SUBU, OP_SLT, OP_SLTU};
    endfunction

endpackage

// File: rtl/alu_opb_sel.sv
module alu_opb_sel
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  alu_op_e           op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] b_reg,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opb
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    logic [PAD_W-1:0] fill;

    always_comb begin
        fill = op_sign_ext(op) ? {PAD_W{imm[IMM_W-1]}} : '0;
        opb  = use_imm ? {fill, imm} : b_reg;
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_s,
    output logic              lt_s,
    output logic              lt_u
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic              cout;

    always_comb begin
        b_x         = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub};
        // Operands agree in sign but the sum does not: out of range.
        ovf_s       = (a[MSB] == b_x[MSB]) && (sum[MSB] != a[MSB]);
        // With subtract selected, no carry out means a borrow: a < b unsigned.
        lt_u        = sub & ~cout;
        lt_s        = sum[MSB] ^ ovf_s;
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SH_W   = 5
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   amt,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (mode)
            2'd0:    y = a << amt;
            2'd1:    y = a >> amt;
            default: y = DATA_W'($signed(a) >>> amt);
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o,
    output logic              ovf_o
);
    localparam int unsigned LO_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              zero;
        logic              ovf;
    } out_t;

    alu_op_e           op;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] sh_y;
    logic              ovf_s, lt_s, lt_u;
    logic [1:0]        sh_mode;
    out_t              out_d, out_q;

    assign op = alu_op_e'(op_i);

    alu_opb_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
        .op      (op),
        .use_imm (use_imm_i),
        .b_reg   (b_i),
        .imm     (imm_i),
        .opb     (opb)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a     (a_i),
        .b     (opb),
        .sub   (op_uses_sub(op)),
        .sum   (sum),
        .ovf_s (ovf_s),
        .lt_s  (lt_s),
        .lt_u  (lt_u)
    );

    always_comb begin
        unique case (op)
            OP_SRL:  sh_mode = 2'd1;
            OP_SRA:  sh_mode = 2'd2;
            default: sh_mode = 2'd0;
        endcase
    end

    alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .a    (a_i),
        .amt  (shamt_i),
        .mode (sh_mode),
        .y    (sh_y)
    );

    always_comb begin
        out_d     = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                out_d.res = sum;
                out_d.ovf = ovf_s;
            end
            OP_ADDU, OP_SUBU:        out_d.res = sum;
            OP_AND:                  out_d.res = a_i & opb;
            OP_OR:                   out_d.res = a_i | opb;
            OP_XOR:                  out_d.res = a_i ^ opb;
            OP_NOR:                  out_d.res = ~(a_i | opb);
            OP_SLT:                  out_d.res = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU:                 out_d.res = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA:  out_d.res = sh_y;
            OP_LUI:                  out_d.res = {imm_i, {LO_W{1'b0}}};
            default:                 out_d.res = '0;
        endcase
        out_d.zero = (out_d.res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{res: '0, zero: 1'b1, ovf: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign zero_o   = out_q.zero;
    assign ovf_o    = out_q.ovf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned SH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [SH_W-1:0]   shamt_i,
    input logic [DATA_W-1:0] result_o,
    input logic              zero_o,
    input logic              ovf_o
);
    localparam int unsigned LO_W = DATA_W - IMM_W;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !($past(op_i) inside {OP_ADD, OP_SUB})) |-> !ovf_o);

    // R7
    slt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) inside {OP_SLT, OP_SLTU}))
            |-> (result_o[DATA_W-1:1] == '0));

    // R9
    lui_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_LUI)
            |-> (result_o == {$past(imm_i), {LO_W{1'b0}}}));

    // R8
    shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) inside {OP_SLL, OP_SRL, OP_SRA})
                 && $past(shamt_i) == '0) |-> (result_o == $past(a_i)));

    // R11
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd14) |-> (result_o == '0 && zero_o && !ovf_o));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (result_o == '0));
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .imm_i    (imm_i),
    .shamt_i  (shamt_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        zero_o, ovf_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    alu_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .use_imm_i(use_imm_i),
        .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .shamt_i(shamt_i),
        .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
    );

    // Driver: present operands after a falling edge, queue the expectation after capture.
    task automatic send(input logic [3:0] op, input logic ui, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh,
                        input logic [31:0] er, input logic eo, input string tag);
        @(negedge clk);
        op_i = op; use_imm_i = ui; a_i = a; b_i = b; imm_i = imm; shamt_i = sh;
        @(posedge clk);
        #1;
        sb_q.push_back('{res: er, ovf: eo, tag: tag});
    endtask

    // Independent model written from the requirement list.
    function automatic void model(input logic [3:0] op, input logic ui, input logic [31:0] a,
                                  input logic [31:0] b, input logic [15:0] imm,
                                  input logic [4:0] sh, output logic [31:0] r, output logic o);
        logic [31:0] bs;
        bit arith;
        arith = (op <= 4'd3) || op == 4'd8 || op == 4'd9;
        if (ui) bs = arith ? {{16{imm[15]}}, imm} : {16'h0000, imm};
        else    bs = b;
        o = 1'b0;
        case (op)
            4'd0: begin r = a + bs; o = (a[31] == bs[31]) && (r[31] != a[31]); end
            4'd1: r = a + bs;
            4'd2: begin r = a - bs; o = (a[31] != bs[31]) && (r[31] != a[31]); end
            4'd3: r = a - bs;
            4'd4: r = a & bs;
            4'd5: r = a | bs;
            4'd6: r = a ^ bs;
            4'd7: r = ~(a | bs);
            4'd8: r = ($signed(a) < $signed(bs)) ? 32'd1 : 32'd0;
            4'd9: r = (a < bs) ? 32'd1 : 32'd0;
            4'd10: r = a << sh;
            4'd11: r = a >> sh;
            4'd12: r = 32'($signed(a) >>> sh);
            4'd13: r = {imm, 16'h0000};
            default: r = 32'h0;
        endcase
    endfunction

    task automatic send_model(input logic [3:0] op, input logic ui, input logic [31:0] a,
                              input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh,
                              input string tag);
        logic [31:0] r;
        logic o;
        model(op, ui, a, b, imm, sh, r, o);
        send(op, ui, a, b, imm, sh, r, o, tag);
    endtask

    // Monitor: compares each queued expectation at the falling edge after capture.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (result_o !== e.res || zero_o !== (e.res == 32'h0) || ovf_o !== e.ovf) begin
                    failures++;
                    $display("FAIL %s: result=%h zero=%b ovf=%b expected result=%h zero=%b ovf=%b",
                             e.tag, result_o, zero_o, ovf_o, e.res, (e.res == 32'h0), e.ovf);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state, with busy inputs
        op_i = 4'd0; a_i = 32'h0000_0005; b_i = 32'h0000_0007;
        repeat (3) @(negedge clk);
        checks++;
        if (result_o !== 32'h0 || zero_o !== 1'b1 || ovf_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: result=%h zero=%b ovf=%b expected 00000000 1 0",
                     result_o, zero_o, ovf_o);
        end
        rst_n = 1'b1;

        // R2 R4: 4 + sext(0xFFFF) = 3
        send(4'd0, 1'b1, 32'h4, 32'h0, 16'hFFFF, 5'd0, 32'h3, 1'b0, "R2 R4 add imm");
        // R4: use_imm=0 ignores imm
        send(4'd0, 1'b0, 32'h4, 32'h10, 16'hFFFF, 5'd0, 32'h14, 1'b0, "R4 reg operand");
        // R5: and with zero-extended immediate
        send(4'd4, 1'b1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'h0000_FFFF, 1'b0, "R5 and imm");
        send(4'd5, 1'b1, 32'h0, 32'h0, 16'h8000, 5'd0, 32'h0000_8000, 1'b0, "R5 or imm");
        send(4'd6, 1'b1, 32'hFFFF_0000, 32'h0, 16'hFFFF, 5'd0, 32'hFFFF_FFFF, 1'b0, "R5 xor imm");
        // R3 overflow boundaries
        send(4'd0, 1'b0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h8000_0000, 1'b1, "R3 add ovf");
        send(4'd1, 1'b0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h8000_0000, 1'b0, "R3 addu no ovf");
        send(4'd2, 1'b0, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b1, "R3 sub ovf");
        send(4'd2, 1'b0, 32'h0, 32'h8000_0000, 16'h0, 5'd0, 32'h8000_0000, 1'b1, "R3 sub minint");
        send(4'd3, 1'b0, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b0, "R3 subu no ovf");
        send(4'd0, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0, "R3 add carry no ovf");
        // R2 R10 subtract to zero
        send(4'd2, 1'b0, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, 1'b0, "R2 R10 sub zero");
        // R6 bitwise
        send(4'd7, 1'b0, 32'h0F0F_0F0F, 32'h00FF_00FF, 16'h0, 5'd0, 32'hF000_F000, 1'b0, "R6 nor");
        send(4'd7, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 5'd0, 32'h0, 1'b0, "R6 R10 nor zero");
        send(4'd4, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 5'd0, 32'h00F0_1234, 1'b0, "R6 and reg");
        // R7 compares
        send(4'd8, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h1, 1'b0, "R7 slt neg");
        send(4'd9, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0, "R7 sltu big");
        send(4'd8, 1'b0, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, 1'b0, "R7 slt equal");
        send(4'd8, 1'b0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, 32'h0, 1'b0, "R7 slt extremes");
        send(4'd8, 1'b1, 32'h0, 32'h0, 16'hFFFF, 5'd0, 32'h0, 1'b0, "R4 R7 slt imm");
        send(4'd9, 1'b1, 32'h0, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b0, "R4 R7 sltu imm");
        // R8 shifts
        send(4'd10, 1'b0, 32'h1, 32'h0, 16'h0, 5'd5, 32'h20, 1'b0, "R8 sll");
        send(4'd10, 1'b0, 32'h8000_0001, 32'h0, 16'h0, 5'd31, 32'h8000_0000, 1'b0, "R8 sll 31");
        send(4'd11, 1'b0, 32'h8000_0000, 32'h0, 16'h0, 5'd4, 32'h0800_0000, 1'b0, "R8 srl");
        send(4'd12, 1'b0, 32'h8000_0000, 32'h0, 16'h0, 5'd4, 32'hF800_0000, 1'b0, "R8 sra neg");
        send(4'd12, 1'b0, 32'h4000_0000, 32'h0, 16'h0, 5'd30, 32'h1, 1'b0, "R8 sra pos");
        send(4'd11, 1'b0, 32'hDEAD_BEEF, 32'h0, 16'h0, 5'd0, 32'hDEAD_BEEF, 1'b0, "R8 srl 0");
        // R9 upper immediate
        send(4'd13, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 5'd0, 32'h1234_0000, 1'b0, "R9 lui");
        send(4'd13, 1'b1, 32'h1, 32'h0, 16'h0000, 5'd0, 32'h0, 1'b0, "R9 R10 lui zero");
        // R11 unused codes
        send(4'd14, 1'b0, 32'h5, 32'h7, 16'h0, 5'd0, 32'h0, 1'b0, "R11 code 14");
        send(4'd15, 1'b1, 32'h7FFF_FFFF, 32'h1, 16'h1, 5'd3, 32'h0, 1'b0, "R11 code 15");

        // R2 R10: random pass over all codes against the model
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            logic [15:0] ri;
            ra = $urandom;
            rb = (i % 7 == 0) ? ra : $urandom;
            ri = 16'($urandom);
            send_model(4'($urandom), 1'($urandom), ra, rb, ri, 5'($urandom), "R2 R10 random");
        end

        @(negedge clk);
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule